// File: doc/BRIEF.md
# Serial Control Slave with Shared-Pin Blanking

This block is the transceiver-side end of a slow two-wire serial control bus. A master clocks it with a serial clock and sends command and write data on a line that also carries the transmit data for the light emitter. Read responses go back on a line that normally carries the detector's receive data. The slave holds three 8-bit control registers. It decodes write and read transactions, and it gates the emitter drive and the detector output so that bus traffic and optical traffic never mix on the shared pins.

Both bus inputs pass through a two-flop synchronizer into the system clock domain. Every protocol step happens on a synchronized rising edge of the serial clock. The first rising edge after idle announces a transaction and blanks the emitter. The next edge is a start bit, followed by a command byte that is sent LSB first. A write then continues with a second start bit and a data byte. A read continues with one turnaround edge, and after it the slave drives a response start bit and the data byte on the return line. The master closes a read with a high-then-low marker on the data line. After reset, the slave waits for an initialization run of serial clock edges with the data line held low before it takes part in any traffic.

Top module: `sctl_slave`

## Requirements
- R1: `led_en_o` is 1 only while the slave is idle, initialized, and control register 0 has bit 0 (shutdown) and bit 2 (emitter off) both clear. It is 0 from the first serial clock rising edge of a transaction onward.
- R2: A write takes effect on its final (19th) rising edge. On that same edge the slave returns to idle, so `led_en_o` comes back when register 0 allows it.
- R3: `det_en_o` is 0 while `srdat_oe_o` is 1 (response phase), and also in shutdown, when register 0 bit 1 (receive off) is set, or before initialization. Otherwise it is 1.
- R4: Data is sampled on rising serial clock edges. On the turnaround edge of a read, `srdat_o` becomes 0 (the response start bit) and `srdat_oe_o` becomes 1. On each of the next 8 rising edges, `srdat_o` presents the next read data bit, LSB first.
- R5: Framing: 1 announce edge, 1 start-bit edge, then 8 command bits LSB first. Command bit 7 = 1 selects a read, and bits 6:0 give the register index. A write then takes 1 start-bit edge and 8 data bits LSB first, with no gaps.
- R6: After reset, register 0 = 0x07, register 1 = 0x00 (SIR-mode code), register 2 = 0xFF (full-power code), and `led_en_o`, `det_en_o` and `srdat_oe_o` are 0.
- R7: A read ends on the first response-phase rising edge that samples the data line low after the previous edge sampled it high. On that edge `srdat_oe_o` drops.
- R8: After reset, the slave ignores all traffic until it sees 30 consecutive rising edges with the data line low. A high sample restarts the count.
- R9: A write to an index above 2 changes no register. A read of an index above 2 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial bus clock (asynchronous) |
| swdat_i | input | 1 | Bus write data, shared with emitter transmit data |
| srdat_o | output | 1 | Response data bit for the return line |
| srdat_oe_o | output | 1 | Return line carries response data (detector blanked) |
| led_en_o | output | 1 | Gate enabling transmit data onto the emitter |
| det_en_o | output | 1 | Gate enabling detector output onto the return line |
| ctrl0_o | output | 8 | Control register 0 (bit 0 shutdown, bit 1 receive off, bit 2 emitter off) |
| ctrl1_o | output | 8 | Control register 1 (mode code) |
| ctrl2_o | output | 8 | Control register 2 (power code) |

## Verification
The initialization run is attacked with a low run that is broken by a high bit before it reaches 30 edges, and then with a write attempt during that run. A design that counted total edges rather than consecutive ones would accept that write. Reads of out-of-range indices and writes to index 5 expose a decoder that folds the index onto 2 bits and hits a real register. The emitter gate is checked right after the announce edge of a transaction and again after its final edge, which catches a slave that blanks late or releases one edge early. Each read is closed with the high-then-low marker, and the bench checks that the response enable and the detector gate switch back exactly on the low edge, not on a bit count.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned NREG      = 3;
  localparam int unsigned IDXW      = 7;
  localparam int unsigned INIT_RUN  = 30;
  localparam int unsigned SYNC_STG  = 2;

  localparam int unsigned B_SHDN    = 0;
  localparam int unsigned B_RXOFF   = 1;
  localparam int unsigned B_LEDOFF  = 2;

  localparam logic [NREG-1:0][DW-1:0] RST_VAL = {8'hFF, 8'h00, 8'h07};

  typedef enum logic [2:0] {
    S_INIT, S_IDLE, S_START, S_CMD, S_WSTART, S_WDATA, S_TURN, S_RESP
  } seq_st_t;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int unsigned W   = 2,
  parameter int unsigned STG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STG-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STG-2:0], d_i};
  end

  assign q_o = chain_q[STG-1];
endmodule

// File: rtl/sctl_seq.sv
module sctl_seq
  import sctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_s,
  input  logic            swdat_s,
  input  logic [DW-1:0]   rd_data_i,
  output logic            wr_en_o,
  output logic [IDXW-1:0] idx_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            idle_o,
  output logic            resp_o,
  output logic            inited_o,
  output logic            srdat_o
);
  localparam int unsigned ICW = $clog2(INIT_RUN + 1);
  localparam int unsigned BCW = $clog2(DW);

  seq_st_t        st_q, st_n;
  logic [BCW-1:0] cnt_q, cnt_n;
  logic [ICW-1:0] init_q, init_n;
  logic [DW-1:0]  sh_q, sh_n, cmd_q, cmd_n, tx_q, tx_n;
  logic           prev_q, prev_n, srd_q, srd_n, sclk_d;
  logic           rise;

  assign rise = sclk_s & ~sclk_d;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; init_n = init_q; sh_n = sh_q;
    cmd_n = cmd_q; tx_n = tx_q; prev_n = prev_q; srd_n = srd_q;
    wr_en_o = 1'b0;
    if (rise) begin
      case (st_q)
        S_INIT: begin
          if (swdat_s) init_n = '0;
          else if (init_q == ICW'(INIT_RUN - 1)) begin
            init_n = '0;
            st_n   = S_IDLE;
          end else init_n = init_q + 1'b1;
        end
        S_IDLE:   st_n = S_START;
        S_START:  begin st_n = S_CMD; cnt_n = '0; end
        S_CMD: begin
          sh_n  = {swdat_s, sh_q[DW-1:1]};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == BCW'(DW - 1)) begin
            cmd_n = sh_n;
            st_n  = swdat_s ? S_TURN : S_WSTART;
          end
        end
        S_WSTART: begin st_n = S_WDATA; cnt_n = '0; end
        S_WDATA: begin
          sh_n  = {swdat_s, sh_q[DW-1:1]};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == BCW'(DW - 1)) begin
            wr_en_o = 1'b1;
            st_n    = S_IDLE;
          end
        end
        S_TURN: begin
          st_n   = S_RESP;
          tx_n   = rd_data_i;
          srd_n  = 1'b0;
          prev_n = 1'b0;
        end
        S_RESP: begin
          srd_n  = tx_q[0];
          tx_n   = {1'b1, tx_q[DW-1:1]};
          prev_n = swdat_s;
          if (prev_q && !swdat_s) st_n = S_IDLE;
        end
        default: st_n = S_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_INIT; cnt_q <= '0; init_q <= '0; sh_q <= '0;
      cmd_q <= '0; tx_q <= '0; prev_q <= 1'b0; srd_q <= 1'b0; sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (rise) begin
        st_q <= st_n; cnt_q <= cnt_n; init_q <= init_n; sh_q <= sh_n;
        cmd_q <= cmd_n; tx_q <= tx_n; prev_q <= prev_n; srd_q <= srd_n;
      end
    end
  end

  assign wr_data_o = sh_n;
  assign idx_o     = cmd_q[IDXW-1:0];
  assign idle_o    = (st_q == S_IDLE);
  assign resp_o    = (st_q == S_RESP);
  assign inited_o  = (st_q != S_INIT);
  assign srdat_o   = srd_q;

  assert_write_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (st_q == S_IDLE));
  assert_no_init_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_INIT) |-> !wr_en_o);
  assert_resp_from_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(st_q) && st_q == S_RESP) |-> ($past(st_q) == S_TURN) && !srd_q);
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [IDXW-1:0]           idx_i,
  input  logic [DW-1:0]             wr_data_i,
  output logic [DW-1:0]             rd_data_o,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  logic [NREG-1:0][DW-1:0] r_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 r_q[g] <= RST_VAL[g];
      else if (wr_en_i && idx_i == IDXW'(g))      r_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (idx_i == IDXW'(i)) rd_data_o = r_q[i];
  end

  assign regs_o = r_q;

  assert_oob_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_i >= IDXW'(NREG)) |=> $stable(r_q));
endmodule

// File: rtl/sctl_slave.sv
module sctl_slave
  import sctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          swdat_i,
  output logic          srdat_o,
  output logic          srdat_oe_o,
  output logic          led_en_o,
  output logic          det_en_o,
  output logic [DW-1:0] ctrl0_o,
  output logic [DW-1:0] ctrl1_o,
  output logic [DW-1:0] ctrl2_o
);
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_meta <= 1'b0; rst_sync <= 1'b0; end
    else        begin rst_meta <= 1'b1; rst_sync <= rst_meta; end
  end

  logic [1:0] bus_s;
  sctl_sync #(.W(2), .STG(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_sync), .d_i({sclk_i, swdat_i}), .q_o(bus_s));

  logic                    wr_en, idle, resp, inited;
  logic [IDXW-1:0]         idx;
  logic [DW-1:0]           wr_data, rd_data;
  logic [NREG-1:0][DW-1:0] regs;

  sctl_seq u_seq (
    .clk(clk), .rst_n(rst_sync), .sclk_s(bus_s[1]), .swdat_s(bus_s[0]),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .idx_o(idx), .wr_data_o(wr_data),
    .idle_o(idle), .resp_o(resp), .inited_o(inited), .srdat_o(srdat_o));

  sctl_regs u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en_i(wr_en), .idx_i(idx),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .regs_o(regs));

  assign ctrl0_o    = regs[0];
  assign ctrl1_o    = regs[1];
  assign ctrl2_o    = regs[2];
  assign srdat_oe_o = resp;
  assign led_en_o   = idle & ~regs[0][B_SHDN] & ~regs[0][B_LEDOFF];
  assign det_en_o   = inited & ~resp & ~regs[0][B_SHDN] & ~regs[0][B_RXOFF];

  assert_led_blank_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    !idle |-> !led_en_o);
  assert_det_blank_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    srdat_oe_o |-> !det_en_o);
  assert_init_gate_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    !inited |-> (!led_en_o && !det_en_o && !srdat_oe_o));
endmodule

// File: tb/sctl_slave_tb.sv
module sctl_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n, sclk, swdat;
  logic srdat, srdat_oe, led_en, det_en;
  logic [7:0] c0, c1, c2;
  int tests = 0, fails = 0;
  logic [7:0] shadow [3];

  always #5 clk = ~clk;

  sctl_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .swdat_i(swdat),
    .srdat_o(srdat), .srdat_oe_o(srdat_oe), .led_en_o(led_en), .det_en_o(det_en),
    .ctrl0_o(c0), .ctrl1_o(c1), .ctrl2_o(c2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_led(input logic [7:0] r0);
    return ~r0[0] & ~r0[2];
  endfunction
  function automatic logic exp_det(input logic [7:0] r0);
    return ~r0[0] & ~r0[1];
  endfunction
  function automatic logic [7:0] exp_rd(input int idx);
    return (idx < 3) ? shadow[idx] : 8'h00;
  endfunction

  task automatic pulse(input logic b);
    sclk = 1'b0; swdat = b;
    repeat (6) @(posedge clk);
    sclk = 1'b1;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) pulse(v[i]);
  endtask

  task automatic do_write(input logic [6:0] idx, input logic [7:0] d, input bit live);
    pulse(1'b0);
    if (live) chk("R1 emitter blanked after announce edge", led_en, 0);
    pulse(1'b0);
    send_byte({1'b0, idx});
    pulse(1'b0);
    send_byte(d);
    if (live && idx < 3) shadow[idx] = d;
  endtask

  task automatic do_read(input logic [6:0] idx, output logic [7:0] got);
    pulse(1'b0);
    pulse(1'b0);
    send_byte({1'b1, idx});
    pulse(1'b0);
    chk("R4 response start bit", {srdat_oe, srdat}, 2'b10);
    chk("R3 detector blanked in response", det_en, 0);
    for (int i = 0; i < 8; i++) begin
      pulse(i == 7);
      got[i] = srdat;
    end
    chk("R7 response held until marker", srdat_oe, 1);
    pulse(1'b0);
    chk("R7 marker low edge ends read", srdat_oe, 0);
    chk("R3 detector restored after read", det_en, exp_det(shadow[0]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] got;
    void'($urandom(32'd4711));
    rst_n = 1'b0; sclk = 1'b0; swdat = 1'b0;
    shadow[0] = 8'h07; shadow[1] = 8'h00; shadow[2] = 8'hFF;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk("R6 reg0 reset", c0, 8'h07);
    chk("R6 reg1 reset", c1, 8'h00);
    chk("R6 reg2 reset", c2, 8'hFF);
    chk("R6 enables low at reset", {led_en, det_en, srdat_oe}, 3'b000);

    // R8: broken low run, then a write attempt ending with a high bit
    for (int i = 0; i < 20; i++) pulse(1'b0);
    do_write(7'd2, 8'hA5, 1'b0);
    chk("R8 write ignored before init", c2, 8'hFF);
    chk("R8 detector off before init", det_en, 0);
    for (int i = 0; i < 30; i++) pulse(1'b0);
    chk("R8 init done, reg0 still blocks gates", {led_en, det_en}, 2'b00);

    do_write(7'd0, 8'h00, 1'b1);
    chk("R2 reg0 written on final edge", c0, 8'h00);
    chk("R2 emitter restored on final edge", led_en, 1);
    chk("R3 detector enabled when idle", det_en, 1);
    do_write(7'd2, 8'h5A, 1'b1);
    chk("R5 reg2 LSB-first write", c2, 8'h5A);

    do_write(7'd5, 8'h3C, 1'b1);
    chk("R9 oob write reg0", c0, shadow[0]);
    chk("R9 oob write reg1", c1, shadow[1]);
    chk("R9 oob write reg2", c2, shadow[2]);
    do_read(7'd3, got);
    chk("R9 oob read returns zero", got, 8'h00);
    do_read(7'd2, got);
    chk("R4 read reg2 LSB first", got, 8'h5A);

    for (int n = 0; n < 40; n++) begin
      int idx;
      logic [7:0] d;
      idx = $urandom % 5;
      d = $urandom;
      if (idx == 0) d[2:0] = d[2:0] & 3'b010;
      if ($urandom % 2) begin
        do_write(7'(idx), d, 1'b1);
        chk("R5 random write reg0", c0, shadow[0]);
        chk("R5 random write reg1", c1, shadow[1]);
        chk("R5 random write reg2", c2, shadow[2]);
        chk("R2 emitter after write", led_en, exp_led(shadow[0]));
      end else begin
        do_read(7'(idx), got);
        chk("R4 random read data", got, exp_rd(idx));
      end
    end

    do_write(7'd0, 8'h01, 1'b1);
    chk("R1 shutdown gates emitter", led_en, 0);
    chk("R3 shutdown gates detector", det_en, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule